// File: doc/BRIEF.md
# Two-Wire Command Decoder for a Dual Wiper Register Bank

This block is the slave-side front end of a two-wire open-drain bus. It works on SCL and SDA as sampled by the system clock. It resynchronises both lines and finds the bus start and stop conditions. It then assembles bytes MSB first, matches a device address, decodes an instruction byte and runs one of four transaction flows. The flows are a two-byte command, a three-byte write, a three-byte read, and a free-running step mode. The block pulls SDA low to acknowledge and to send read data. The caller wires `sda_oe_o` to an open-drain pad.

Its result is a stream of one-cycle command strobes for a neighbouring register bank. Each strobe carries a command code, a potentiometer select, a register select and a value. The bank returns a busy flag while a nonvolatile store is in progress. It also returns a lock flag and the read value for the current selection. Commands that change register contents are issued only when a stop closes a complete transaction, and a locked bank never receives a store command. A busy bank makes the block ignore its own address, so a master can poll until the store is done.

Top module: `twcmd_slave`

## Requirements
- R1: A start (SDA falling while SCL is high) begins address reception from any state, drops any partly received transaction and releases SDA. A stop (SDA rising while SCL is high) returns the block to idle.
- R2: The first byte after a start is acknowledged only when its bits [7:4] are 0101 and its bits [3:0] equal `dev_addr_i`. Otherwise SDA stays released for the rest of the frame, until the next start.
- R3: While `nv_busy_i` is high, a matching address byte is not acknowledged. Once it is low again, the same byte is acknowledged.
- R4: In the instruction byte, bits [7:4] are the opcode, bits [3:2] the register select, bit 1 is ignored and bit 0 the potentiometer select. The only known opcodes are 1001, 1010, 1011, 1100, 1101, 1110, 0001, 1000 and 0010. Any other opcode is not acknowledged and the block goes idle.
- R5: The block acknowledges a known instruction byte, and acknowledges the data byte of a write (opcodes 1010 and 1100).
- R6: For opcodes 1001 and 1011 the block sends 00 followed by `rd_data_i` MSB first, starting after the instruction acknowledge. It releases SDA after the eighth bit and ignores the master's acknowledge.
- R7: A stop that follows a complete transaction raises `cmd_stb_o` for one cycle. It carries `cmd_op_o` (1010→1, 1100→2, 1101→3, 1110→4, 0001→5, 1000→6), the latched selects and, for writes, the data byte bits [5:0] on `wdata_o`. A stop before the transaction is complete issues nothing.
- R8: Store commands (codes 2, 4 and 6) are dropped at the stop when `nv_lock_i` is high. They are still acknowledged.
- R9: After opcode 0010, each SCL pulse produces one strobe at its falling edge: code 7 if SDA was high at the rising edge, code 8 if it was low. The SCL pulse that carries the stop produces none.
- R10: SDA is pulled low only starting in an SCL-low period.
- R11: After reset SDA is released, `cmd_stb_o` is low and `cmd_op_o` is 0. Every strobe lasts exactly one cycle. While a read opcode is latched, `cmd_op_o` holds 9 for 1001 and 10 for 1011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dev_addr_i | input | 4 | Strapped low nibble of the device address |
| nv_busy_i | input | 1 | Bank is performing a nonvolatile store |
| nv_lock_i | input | 1 | Bank refuses nonvolatile stores |
| rd_data_i | input | DATA_W | Bank value for the current selection |
| sda_oe_o | output | 1 | Pull SDA low when high |
| cmd_stb_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 4 | Command code (held between strobes) |
| pot_sel_o | output | 1 | Potentiometer select |
| reg_sel_o | output | 2 | Register select |
| wdata_o | output | DATA_W | Value of the last write data byte |

## Verification
In step mode the final SCL pulse both arms a step at its rising edge and carries the stop condition before its falling edge. The stop must win, and no decrement may escape. The bench clocks two up-steps and one down-step. It then closes with a stop and requires exactly three strobes with the right codes in the scoreboard. In the same way, the lock flag is sampled in the very cycle the stop is seen. A locked store that is fully acknowledged must still leave the strobe count unchanged.

// File: rtl/tw_pkg.sv
package tw_pkg;

   typedef enum logic [3:0] {
      CMD_NONE      = 4'd0,
      CMD_SET_WIPER = 4'd1,
      CMD_SET_REG   = 4'd2,
      CMD_LOAD      = 4'd3,
      CMD_SAVE      = 4'd4,
      CMD_LOAD_ALL  = 4'd5,
      CMD_SAVE_ALL  = 4'd6,
      CMD_STEP_UP   = 4'd7,
      CMD_STEP_DN   = 4'd8,
      CMD_RD_WIPER  = 4'd9,
      CMD_RD_REG    = 4'd10
   } cmd_e;

   typedef enum logic [1:0] {
      FLOW_SHORT,
      FLOW_WRITE,
      FLOW_READ,
      FLOW_STEP
   } flow_e;

   typedef struct packed {
      logic  known;
      flow_e flow;
      cmd_e  cmd;
   } op_info_t;

   function automatic logic cmd_is_nv(input cmd_e c);
      return (c == CMD_SET_REG) || (c == CMD_SAVE) || (c == CMD_SAVE_ALL);
   endfunction

endpackage

// File: rtl/tw_line_ev.sv
module tw_line_ev #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   logic [SYNC_STAGES-1:0] scl_sh;
   logic [SYNC_STAGES-1:0] sda_sh;
   logic                   scl_q;
   logic                   sda_q;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_stages
         $error("tw_line_ev: SYNC_STAGES must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_sh <= '1;
               sda_sh <= '1;
            end else begin
               scl_sh <= scl_i;
               sda_sh <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_sh <= '1;
               sda_sh <= '1;
            end else begin
               scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
               sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   assign scl_o = scl_sh[SYNC_STAGES-1];
   assign sda_o = sda_sh[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_o;
         sda_q <= sda_o;
      end
   end

   assign scl_rise_o = scl_o & ~scl_q;
   assign scl_fall_o = ~scl_o & scl_q;
   assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
   assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/tw_opdec.sv
module tw_opdec
   import tw_pkg::*;
(
   input  logic [3:0] opcode_i,
   output op_info_t   info_o
);

   always_comb begin
      info_o = '{known: 1'b1, flow: FLOW_SHORT, cmd: CMD_NONE};
      unique case (opcode_i)
         4'b1001: begin info_o.flow = FLOW_READ;  info_o.cmd = CMD_RD_WIPER;  end
         4'b1011: begin info_o.flow = FLOW_READ;  info_o.cmd = CMD_RD_REG;    end
         4'b1010: begin info_o.flow = FLOW_WRITE; info_o.cmd = CMD_SET_WIPER; end
         4'b1100: begin info_o.flow = FLOW_WRITE; info_o.cmd = CMD_SET_REG;   end
         4'b1101: info_o.cmd = CMD_LOAD;
         4'b1110: info_o.cmd = CMD_SAVE;
         4'b0001: info_o.cmd = CMD_LOAD_ALL;
         4'b1000: info_o.cmd = CMD_SAVE_ALL;
         4'b0010: begin info_o.flow = FLOW_STEP;  info_o.cmd = CMD_STEP_UP;   end
         default: info_o.known = 1'b0;
      endcase
   end

endmodule

// File: rtl/tw_seq.sv
module tw_seq
   import tw_pkg::*;
#(
   parameter int         DATA_W   = 6,
   parameter logic [3:0] DEV_TYPE = 4'b0101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_i,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [3:0]        dev_addr_i,
   input  logic              nv_busy_i,
   input  logic              nv_lock_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  op_info_t          info_i,
   output logic [7:0]        rx_byte_o,
   output logic              sda_oe_o,
   output logic              cmd_stb_o,
   output cmd_e              cmd_op_o,
   output logic              pot_sel_o,
   output logic [1:0]        reg_sel_o,
   output logic [DATA_W-1:0] wdata_o
);

   localparam int         BYTE_W   = 8;
   localparam int         PAD_W    = BYTE_W - DATA_W;
   localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

   typedef enum logic [2:0] {
      PH_IDLE, PH_ADDR, PH_INSTR, PH_WDATA, PH_RDATA, PH_STEP, PH_HOLD
   } ph_e;

   ph_e         ph, ph_after, ph_next;
   logic [3:0]  bcnt;
   logic [7:0]  rx_sh, tx_sh;
   logic [7:0]  rd_byte;
   logic        in_ack, pend, step_arm, step_dir, accept;

   assign rx_byte_o = rx_sh;
   assign rd_byte   = {{PAD_W{1'b0}}, rd_data_i};

   always_comb begin
      accept  = 1'b0;
      ph_next = PH_IDLE;
      case (ph)
         PH_ADDR: begin
            accept  = (rx_sh[7:4] == DEV_TYPE) && (rx_sh[3:0] == dev_addr_i) && !nv_busy_i;
            ph_next = PH_INSTR;
         end
         PH_INSTR: begin
            accept = info_i.known;
            case (info_i.flow)
               FLOW_WRITE: ph_next = PH_WDATA;
               FLOW_READ:  ph_next = PH_RDATA;
               FLOW_STEP:  ph_next = PH_STEP;
               default:    ph_next = PH_HOLD;
            endcase
         end
         PH_WDATA: begin
            accept  = 1'b1;
            ph_next = PH_HOLD;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         ph_after  <= PH_IDLE;
         bcnt      <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         in_ack    <= 1'b0;
         pend      <= 1'b0;
         step_arm  <= 1'b0;
         step_dir  <= 1'b0;
         sda_oe_o  <= 1'b0;
         cmd_stb_o <= 1'b0;
         cmd_op_o  <= CMD_NONE;
         pot_sel_o <= 1'b0;
         reg_sel_o <= '0;
         wdata_o   <= '0;
      end else begin
         cmd_stb_o <= 1'b0;
         if (start_i) begin
            ph       <= PH_ADDR;
            bcnt     <= '0;
            in_ack   <= 1'b0;
            pend     <= 1'b0;
            step_arm <= 1'b0;
            sda_oe_o <= 1'b0;
         end else if (stop_i) begin
            if (ph == PH_HOLD && pend && !(cmd_is_nv(cmd_op_o) && nv_lock_i))
               cmd_stb_o <= 1'b1;
            ph       <= PH_IDLE;
            in_ack   <= 1'b0;
            pend     <= 1'b0;
            step_arm <= 1'b0;
            sda_oe_o <= 1'b0;
         end else begin
            case (ph)
               PH_ADDR, PH_INSTR, PH_WDATA: begin
                  if (scl_rise_i && !in_ack && bcnt != LAST_BIT) begin
                     rx_sh <= {rx_sh[6:0], sda_i};
                     bcnt  <= bcnt + 4'd1;
                  end else if (scl_fall_i && in_ack) begin
                     in_ack   <= 1'b0;
                     bcnt     <= '0;
                     ph       <= ph_after;
                     sda_oe_o <= 1'b0;
                     if (ph_after == PH_RDATA) begin
                        tx_sh    <= rd_byte;
                        sda_oe_o <= ~rd_byte[7];
                     end
                     if (ph_after == PH_HOLD)
                        pend <= 1'b1;
                  end else if (scl_fall_i && bcnt == LAST_BIT) begin
                     if (accept) begin
                        in_ack   <= 1'b1;
                        sda_oe_o <= 1'b1;
                        ph_after <= ph_next;
                        if (ph == PH_INSTR) begin
                           cmd_op_o  <= info_i.cmd;
                           reg_sel_o <= rx_sh[3:2];
                           pot_sel_o <= rx_sh[0];
                        end
                        if (ph == PH_WDATA)
                           wdata_o <= rx_sh[DATA_W-1:0];
                     end else begin
                        ph <= PH_IDLE;
                     end
                  end
               end
               PH_RDATA: begin
                  if (scl_rise_i) begin
                     bcnt <= bcnt + 4'd1;
                  end else if (scl_fall_i) begin
                     if (bcnt == LAST_BIT) begin
                        sda_oe_o <= 1'b0;
                        ph       <= PH_HOLD;
                     end else begin
                        tx_sh    <= {tx_sh[6:0], 1'b0};
                        sda_oe_o <= ~tx_sh[6];
                     end
                  end
               end
               PH_STEP: begin
                  if (scl_rise_i) begin
                     step_arm <= 1'b1;
                     step_dir <= sda_i;
                  end else if (scl_fall_i && step_arm) begin
                     step_arm  <= 1'b0;
                     cmd_stb_o <= 1'b1;
                     cmd_op_o  <= step_dir ? CMD_STEP_UP : CMD_STEP_DN;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/twcmd_slave.sv
module twcmd_slave
   import tw_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         DATA_W      = 6,
   parameter logic [3:0] DEV_TYPE    = 4'b0101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [3:0]        dev_addr_i,
   input  logic              nv_busy_i,
   input  logic              nv_lock_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              sda_oe_o,
   output logic              cmd_stb_o,
   output logic [3:0]        cmd_op_o,
   output logic              pot_sel_o,
   output logic [1:0]        reg_sel_o,
   output logic [DATA_W-1:0] wdata_o
);

   generate
      if (DATA_W < 1 || DATA_W > 6) begin : g_bad_width
         $error("twcmd_slave: DATA_W must lie in 1..6");
      end
   endgenerate

   logic     scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic [7:0] rx_byte;
   op_info_t op_info;
   cmd_e     cmd_op;

   tw_line_ev #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_o      (scl_s),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_ev),
      .stop_o     (stop_ev)
   );

   tw_opdec u_dec (
      .opcode_i (rx_byte[7:4]),
      .info_o   (op_info)
   );

   tw_seq #(.DATA_W(DATA_W), .DEV_TYPE(DEV_TYPE)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sda_i      (sda_s),
      .scl_rise_i (scl_rise),
      .scl_fall_i (scl_fall),
      .start_i    (start_ev),
      .stop_i     (stop_ev),
      .dev_addr_i (dev_addr_i),
      .nv_busy_i  (nv_busy_i),
      .nv_lock_i  (nv_lock_i),
      .rd_data_i  (rd_data_i),
      .info_i     (op_info),
      .rx_byte_o  (rx_byte),
      .sda_oe_o   (sda_oe_o),
      .cmd_stb_o  (cmd_stb_o),
      .cmd_op_o   (cmd_op),
      .pot_sel_o  (pot_sel_o),
      .reg_sel_o  (reg_sel_o),
      .wdata_o    (wdata_o)
   );

   assign cmd_op_o = cmd_op;

endmodule

// File: rtl/twcmd_slave_chk.sv
module twcmd_slave_chk
   import tw_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       scl_fall,
   input logic       stop_ev,
   input logic       nv_lock_i,
   input logic       sda_oe_o,
   input logic       cmd_stb_o,
   input logic [3:0] cmd_op_o
);

   logic step_op;
   assign step_op = (cmd_op_o == CMD_STEP_UP) || (cmd_op_o == CMD_STEP_DN);

   // R10
   oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_s);

   // R11
   stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb_o |=> !cmd_stb_o);

   // R7
   issue_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb_o && !step_op) |-> $past(stop_ev));

   // R9
   step_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb_o && step_op) |-> $past(scl_fall));

   // R8
   lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb_o && cmd_is_nv(cmd_e'(cmd_op_o))) |-> !$past(nv_lock_i));

endmodule

bind twcmd_slave twcmd_slave_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .scl_fall  (scl_fall),
   .stop_ev   (stop_ev),
   .nv_lock_i (nv_lock_i),
   .sda_oe_o  (sda_oe_o),
   .cmd_stb_o (cmd_stb_o),
   .cmd_op_o  (cmd_op_o)
);

// File: tb/twcmd_slave_tb.sv
`timescale 1ns/1ps
module twcmd_slave_tb;

   localparam int         HALF     = 8;
   localparam int         WD_LIMIT = 150000;
   localparam logic [3:0] MY_ADDR  = 4'hA;
   localparam logic [7:0] ADDR_OK  = 8'h5A;

   typedef struct packed {
      logic [3:0] op;
      logic       pot;
      logic [1:0] rs;
      logic [5:0] wd;
      logic       use_wd;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       scl_m, sda_m;
   logic       nv_busy, nv_lock;
   logic [5:0] rd_data;
   logic       sda_oe, cmd_stb, pot_sel;
   logic [3:0] cmd_op;
   logic [1:0] reg_sel;
   logic [5:0] wdata;
   wire        sda_bus = sda_m & ~sda_oe;

   int total = 0;
   int bad   = 0;
   int n_stb = 0;
   bit done  = 1'b0;
   exp_t sb_q[$];

   always #2 clk = ~clk;

   assign rd_data = {pot_sel, reg_sel, cmd_op[2:0]};

   twcmd_slave u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_bus),
      .dev_addr_i (MY_ADDR),
      .nv_busy_i  (nv_busy),
      .nv_lock_i  (nv_lock),
      .rd_data_i  (rd_data),
      .sda_oe_o   (sda_oe),
      .cmd_stb_o  (cmd_stb),
      .cmd_op_o   (cmd_op),
      .pot_sel_o  (pot_sel),
      .reg_sel_o  (reg_sel),
      .wdata_o    (wdata)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_cmd(input logic [3:0] op, input logic pot, input logic [1:0] rs,
                             input logic [5:0] wd, input logic use_wd);
      sb_q.push_back('{op: op, pot: pot, rs: rs, wd: wd, use_wd: use_wd});
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && cmd_stb) begin
         exp_t e;
         exp_t a;
         n_stb++;
         a = '{op: cmd_op, pot: pot_sel, rs: reg_sel, wd: wdata, use_wd: 1'b0};
         if (sb_q.size() == 0) begin
            check(1'b0, "R7 unexpected strobe", int'(a), 0);
         end else begin
            e = sb_q.pop_front();
            a.use_wd = e.use_wd;
            if (!e.use_wd) a.wd = e.wd;
            check(a == e, "R7 strobe content", int'(a), int'(e));
         end
      end
   end

   task automatic bus_start();
      sda_m = 1'b1; tick(HALF);
      scl_m = 1'b1; tick(HALF);
      sda_m = 1'b0; tick(HALF);
      scl_m = 1'b0; tick(HALF);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(HALF);
      scl_m = 1'b1; tick(HALF);
      sda_m = 1'b1; tick(HALF);
   endtask

   task automatic put_bit(input logic v);
      sda_m = v;    tick(HALF);
      scl_m = 1'b1; tick(HALF);
      scl_m = 1'b0; tick(HALF);
   endtask

   task automatic wr_byte(input logic [7:0] b, output bit ackd);
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      sda_m = 1'b1; tick(HALF);
      scl_m = 1'b1; tick(HALF);
      ackd  = (sda_bus == 1'b0);
      scl_m = 1'b0; tick(HALF);
   endtask

   task automatic rd_byte(output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(HALF);
         scl_m = 1'b1; tick(HALF);
         b[i]  = sda_bus;
         scl_m = 1'b0;
      end
      tick(HALF);
      put_bit(1'b1);
   endtask

   task automatic short_cmd(input logic [7:0] instr, input string req);
      bit a;
      bus_start();
      wr_byte(ADDR_OK, a);
      wr_byte(instr, a);  check(a, req, a, 1);
      bus_stop();
      tick(4);
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      if (!done) begin
         check(1'b0, "R11 watchdog", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit a;
      logic [7:0] rb;
      int base;
      scl_m = 1'b1; sda_m = 1'b1; nv_busy = 1'b0; nv_lock = 1'b0; rst_n = 1'b0;
      tick(5);
      check(sda_oe == 1'b0, "R11 reset sda", sda_oe, 0);
      check(cmd_stb == 1'b0, "R11 reset stb", cmd_stb, 0);
      check(cmd_op == 4'd0, "R11 reset op", cmd_op, 0);
      rst_n = 1'b1;
      tick(5);

      // R2 wrong type nibble, then stays silent
      bus_start();
      wr_byte(8'h6A, a); check(!a, "R2 type mismatch", a, 0);
      wr_byte(8'hA1, a); check(!a, "R2 silent after mismatch", a, 0);
      bus_stop();
      // R2 wrong strapped bits
      bus_start();
      wr_byte(8'h5B, a); check(!a, "R2 address mismatch", a, 0);
      bus_stop();

      // R5 R7 write wiper, pot 1, data 0x2A
      expect_cmd(4'd1, 1'b1, 2'd0, 6'h2A, 1'b1);
      bus_start();
      wr_byte(ADDR_OK, a); check(a, "R2 address match", a, 1);
      wr_byte(8'hA1, a);   check(a, "R5 instr ack", a, 1);
      wr_byte(8'h2A, a);   check(a, "R5 data ack", a, 1);
      bus_stop(); tick(4);

      // R7 write register, pot 0 reg 3
      expect_cmd(4'd2, 1'b0, 2'd3, 6'h15, 1'b1);
      bus_start();
      wr_byte(ADDR_OK, a);
      wr_byte(8'hCC, a);
      wr_byte(8'h15, a);   check(a, "R5 data ack store", a, 1);
      bus_stop(); tick(4);

      // R8 locked store: acknowledged, not issued
      nv_lock = 1'b1;
      base = n_stb;
      bus_start();
      wr_byte(ADDR_OK, a);
      wr_byte(8'hCC, a);
      wr_byte(8'h07, a);   check(a, "R8 locked data ack", a, 1);
      bus_stop(); tick(4);
      short_cmd(8'hE4, "R8 locked save ack");
      check(n_stb == base, "R8 locked no strobe", n_stb - base, 0);
      // R8 volatile load still passes while locked
      expect_cmd(4'd3, 1'b1, 2'd2, 6'h0, 1'b0);
      short_cmd(8'hD9, "R4 load instr ack");
      nv_lock = 1'b0;

      // R7 two-byte commands
      expect_cmd(4'd4, 1'b0, 2'd1, 6'h0, 1'b0);
      short_cmd(8'hE4, "R4 save instr ack");
      expect_cmd(4'd5, 1'b0, 2'd1, 6'h0, 1'b0);
      short_cmd(8'h14, "R4 load-all instr ack");
      expect_cmd(4'd6, 1'b0, 2'd0, 6'h0, 1'b0);
      short_cmd(8'h80, "R4 save-all instr ack");

      // R4 unknown opcodes
      base = n_stb;
      bus_start();
      wr_byte(ADDR_OK, a);
      wr_byte(8'h00, a);   check(!a, "R4 unknown 0000 nack", a, 0);
      wr_byte(8'h2A, a);   check(!a, "R4 idle after unknown", a, 0);
      bus_stop();
      bus_start();
      wr_byte(ADDR_OK, a);
      wr_byte(8'h30, a);   check(!a, "R4 unknown 0011 nack", a, 0);
      bus_stop(); tick(4);
      check(n_stb == base, "R4 no strobe", n_stb - base, 0);

      // R3 busy polling
      nv_busy = 1'b1;
      bus_start();
      wr_byte(ADDR_OK, a); check(!a, "R3 busy nack", a, 0);
      bus_stop();
      nv_busy = 1'b0;
      bus_start();
      wr_byte(ADDR_OK, a); check(a, "R3 ack after busy", a, 1);
      bus_stop();

      // R6 reads
      bus_start();
      wr_byte(ADDR_OK, a);
      wr_byte(8'h91, a);   check(a, "R5 read instr ack", a, 1);
      check(cmd_op == 4'd9, "R11 read wiper code", cmd_op, 9);
      rd_byte(rb);         check(rb == 8'h21, "R6 read wiper", rb, 8'h21);
      check(sda_oe == 1'b0, "R6 released after byte", sda_oe, 0);
      bus_stop();
      bus_start();
      wr_byte(ADDR_OK, a);
      wr_byte(8'hBC, a);
      check(cmd_op == 4'd10, "R11 read reg code", cmd_op, 10);
      rd_byte(rb);         check(rb == 8'h1A, "R6 read register", rb, 8'h1A);
      bus_stop(); tick(4);

      // R1 abort by start in the middle of a data byte
      base = n_stb;
      bus_start();
      wr_byte(ADDR_OK, a);
      wr_byte(8'hA1, a);
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
      bus_start();
      wr_byte(ADDR_OK, a); check(a, "R1 address after restart", a, 1);
      bus_stop(); tick(4);
      check(n_stb == base, "R1 aborted no strobe", n_stb - base, 0);

      // R7 stop before the data byte
      bus_start();
      wr_byte(ADDR_OK, a);
      wr_byte(8'hA1, a);
      bus_stop(); tick(4);
      check(n_stb == base, "R7 incomplete no strobe", n_stb - base, 0);

      // R9 step mode, stop pulse must not step
      expect_cmd(4'd7, 1'b1, 2'd0, 6'h0, 1'b0);
      expect_cmd(4'd7, 1'b1, 2'd0, 6'h0, 1'b0);
      expect_cmd(4'd8, 1'b1, 2'd0, 6'h0, 1'b0);
      bus_start();
      wr_byte(ADDR_OK, a);
      wr_byte(8'h21, a);   check(a, "R9 step instr ack", a, 1);
      put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
      bus_stop(); tick(6);
      check(n_stb == base + 3, "R9 step count", n_stb - base, 3);

      tick(10);
      check(sb_q.size() == 0, "R7 all expected issued", sb_q.size(), 0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule